// File: doc/BRIEF.md
# BT Host Interrupt Mask Controller

This block owns the host-visible interrupt mask register of a block-transfer style management channel. The register holds two live bits, an interrupt enable and an interrupt pending flag, and the level interrupt line to the host follows the pending flag. The block does not own the attention flags. It reads the controller-to-host attention and the SMS attention flags from the surrounding register window, and it uses them to decide whether an event should raise or drop the interrupt.

Four sources act on the register: host writes to the mask register, a one-cycle response-ready pulse from the message handler, SMS attention set or clear requests from the management controller, and a cold reset pulse. Two inputs qualify every raise: a static strap that says whether the interrupt line is wired at all, and a global interrupts-allowed level. When several sources act in the same cycle they are applied in a fixed order, and each one sees the result of the ones before it. The new register value shows on the outputs one clock after the cycle in which the sources act.

Top module: `bt_irq_mask`

## Requirements
- R1: `mask_rdata` bit 0 is the enable, bit 1 is the pending flag, and bits above 1 always read 0. `host_irq` equals the pending flag. Writes to bits above 1 have no effect.
- R2: A mask write with bit 0 = 1 while enable is 0 sets enable. It also sets pending when `b2h_atn` or `sms_atn` is 1. The strap and the allowed input do not gate this.
- R3: A mask write with bit 0 = 0 while enable is 1 clears both enable and pending. Pending is never 1 while enable is 0.
- R4: A mask write with bit 1 = 1 clears pending. This is evaluated after the enable change of the same write. A write with bit 1 = 0 leaves pending as the enable rule left it.
- R5: A `rsp_ready` pulse sets pending when `use_irq`, `irq_allowed` and enable are all 1. Otherwise it changes nothing.
- R6: An SMS request (`sms_req` = 1) whose `sms_val` equals the current `sms_atn` changes nothing.
- R7: An SMS set request (`sms_val` = 1 while `sms_atn` = 0) sets pending only when `sms_qual`, `use_irq`, `irq_allowed` and enable are all 1 and `b2h_atn` is 0.
- R8: An SMS clear request (`sms_val` = 0 while `sms_atn` = 1) clears pending only when `b2h_atn` is 0.
- R9: A `cold_rst` pulse clears enable and pending in the next cycle and overrides every other event in that cycle.
- R10: Events in the same cycle are applied in this order: the mask write, then `rsp_ready`, then the SMS request. Each event sees the enable and pending values left by the events before it.
- R11: While `rst_n` is low, enable, pending and `host_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cold_rst | input | 1 | Cold reset pulse, clears the mask register |
| use_irq | input | 1 | Strap: the interrupt line is wired |
| irq_allowed | input | 1 | Global permission to raise interrupts |
| b2h_atn | input | 1 | Controller-to-host attention flag from the register window |
| sms_atn | input | 1 | SMS attention flag from the register window |
| mask_we | input | 1 | Host write strobe for the mask register |
| mask_wdata | input | REG_W | Host write data |
| mask_rdata | output | REG_W | Mask register read value |
| rsp_ready | input | 1 | Response-ready pulse from the message handler |
| sms_req | input | 1 | SMS attention change request |
| sms_val | input | 1 | Requested SMS attention value |
| sms_qual | input | 1 | The SMS set request may raise the interrupt |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The bench reaches every legal register state: idle, enabled, and enabled with pending. From each state it applies every combination of attention flags, qualifiers, write bits, response pulse and SMS request for a single cycle. It compares the result with an arithmetic model of the rules. This exposes four kinds of fault. A design that gates the enable-rise raise with the strap would miss an interrupt that is already owed. A design that lets a write of 0 to bit 1 clear pending would lose interrupts. A design that acts on an SMS request equal to the current flag would raise spurious interrupts. A design that evaluates same-cycle events in a different order would give a different pending value on writes of 0b11 and on a response pulse that arrives with an enabling write. Directed checks cover a cold reset that collides with a raising write, and the power-on state.

// File: rtl/bt_irq_mask.sv
module bt_irq_mask #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold_rst,
  input  logic             use_irq,
  input  logic             irq_allowed,
  input  logic             b2h_atn,
  input  logic             sms_atn,
  input  logic             mask_we,
  input  logic [REG_W-1:0] mask_wdata,
  output logic [REG_W-1:0] mask_rdata,
  input  logic             rsp_ready,
  input  logic             sms_req,
  input  logic             sms_val,
  input  logic             sms_qual,
  output logic             host_irq
);

  localparam int HI_W = REG_W - 2;

  logic en_q, pd_q;
  logic en_n, pd_n;
  logic may_raise;
  logic wr_unused;

  assign may_raise = use_irq & irq_allowed;
  assign wr_unused = ^mask_wdata[REG_W-1:2];

  always_comb begin
    en_n = en_q;
    pd_n = pd_q;
    if (mask_we) begin
      if (mask_wdata[0] && !en_q) begin
        en_n = 1'b1;
        if (b2h_atn || sms_atn) pd_n = 1'b1;
      end else if (!mask_wdata[0] && en_q) begin
        en_n = 1'b0;
        pd_n = 1'b0;
      end
      if (mask_wdata[1]) pd_n = 1'b0;
    end
    if (rsp_ready && may_raise && en_n) pd_n = 1'b1;
    if (sms_req && (sms_val != sms_atn)) begin
      if (sms_val) begin
        if (sms_qual && may_raise && !b2h_atn && en_n) pd_n = 1'b1;
      end else if (!b2h_atn) begin
        pd_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pd_q <= 1'b0;
    end else if (cold_rst) begin
      en_q <= 1'b0;
      pd_q <= 1'b0;
    end else begin
      en_q <= en_n;
      pd_q <= pd_n;
    end
  end

  assign mask_rdata = {{HI_W{1'b0}}, pd_q, en_q};
  assign host_irq   = pd_q;

endmodule

module bt_irq_mask_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cold_rst,
  input logic             use_irq,
  input logic             irq_allowed,
  input logic             sms_atn,
  input logic             mask_we,
  input logic [REG_W-1:0] mask_wdata,
  input logic [REG_W-1:0] mask_rdata,
  input logic             rsp_ready,
  input logic             sms_req,
  input logic             sms_val,
  input logic             host_irq
);

  a_r3_pend_implies_en: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> mask_rdata[0]);

  a_r9_cold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cold_rst |=> (!host_irq && !mask_rdata[0]));

  a_r3_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !mask_wdata[0] && mask_rdata[0] && !cold_rst) |=> (!host_irq && !mask_rdata[0]));

  a_r6_match_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sms_req && (sms_val == sms_atn) && !mask_we && !rsp_ready && !cold_rst) |=> $stable(mask_rdata));

  a_r5_rsp_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && use_irq && irq_allowed && mask_rdata[0] && !mask_we && !sms_req && !cold_rst) |=> host_irq);

endmodule

bind bt_irq_mask bt_irq_mask_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .use_irq(use_irq),
  .irq_allowed(irq_allowed), .sms_atn(sms_atn), .mask_we(mask_we),
  .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .rsp_ready(rsp_ready),
  .sms_req(sms_req), .sms_val(sms_val), .host_irq(host_irq)
);

// File: tb/bt_irq_mask_tb.sv
`timescale 1ns/1ps
module bt_irq_mask_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cold_rst = 1'b0, use_irq = 1'b0, irq_allowed = 1'b0;
  logic b2h_atn = 1'b0, sms_atn = 1'b0, mask_we = 1'b0;
  logic [W-1:0] mask_wdata = '0;
  logic [W-1:0] mask_rdata;
  logic rsp_ready = 1'b0, sms_req = 1'b0, sms_val = 1'b0, sms_qual = 1'b0;
  logic host_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bt_irq_mask #(.REG_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .use_irq(use_irq),
    .irq_allowed(irq_allowed), .b2h_atn(b2h_atn), .sms_atn(sms_atn),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
    .rsp_ready(rsp_ready), .sms_req(sms_req), .sms_val(sms_val),
    .sms_qual(sms_qual), .host_irq(host_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic en, input logic pd,
      input logic b2h, input logic sms, input logic use_i, input logic alw,
      input logic we, input logic d0, input logic d1, input logic rsp,
      input logic req, input logic val, input logic qual);
    logic e, p;
    e = en; p = pd;
    if (we) begin
      if (d0 && !en) begin e = 1; p = p | b2h | sms; end
      else if (!d0 && en) begin e = 0; p = 0; end
      if (d1) p = 0;
    end
    if (rsp && use_i && alw && e) p = 1;
    if (req && val && !sms && qual && use_i && alw && !b2h && e) p = 1;
    if (req && !val && sms && !b2h) p = 0;
    return {p, e};
  endfunction

  task automatic idle();
    cold_rst = 0; mask_we = 0; mask_wdata = '0; rsp_ready = 0;
    sms_req = 0; sms_val = 0; sms_qual = 0; b2h_atn = 0; sms_atn = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check(mask_rdata == '0 && host_irq == 0, "R11 reset state", {host_irq, mask_rdata}, 0);
    rst_n = 1;
    @(negedge clk);

    // R9: cold reset overrides a raising enable write in the same cycle
    use_irq = 1; irq_allowed = 1; b2h_atn = 1;
    mask_we = 1; mask_wdata = 8'h01;
    @(negedge clk);
    check(mask_rdata == 8'h03, "R2 setup for cold", mask_rdata, 8'h03);
    mask_wdata = 8'h00; mask_we = 0; cold_rst = 1; rsp_ready = 1;
    @(negedge clk);
    check(mask_rdata == 8'h00 && !host_irq, "R9 cold clears", mask_rdata, 0);
    cold_rst = 1; rsp_ready = 0; mask_we = 1; mask_wdata = 8'h01;
    @(negedge clk);
    check(mask_rdata == 8'h00 && !host_irq, "R9 cold beats write", mask_rdata, 0);
    idle();

    for (int st = 0; st < 3; st++) begin
      for (int v = 0; v < 2048; v++) begin
        logic en0, pd0;
        logic [1:0] exp;
        string tag;
        en0 = (st != 0); pd0 = (st == 2);
        idle();
        cold_rst = 1;
        @(negedge clk);
        idle();
        if (en0) begin
          mask_we = 1; mask_wdata = 8'h01; b2h_atn = pd0;
          @(negedge clk);
          idle();
        end
        b2h_atn = v[0]; sms_atn = v[1]; use_irq = v[2]; irq_allowed = v[3];
        mask_we = v[4];
        mask_wdata = {W{1'b0}};
        mask_wdata[1:0] = {v[6], v[5]};
        mask_wdata[W-1:2] = (W-2)'(v * 7 + st);
        rsp_ready = v[7]; sms_req = v[8]; sms_val = v[9]; sms_qual = v[10];
        exp = model(en0, pd0, v[0], v[1], v[2], v[3], v[4], v[5], v[6],
                    v[7], v[8], v[9], v[10]);
        tag = "";
        if (v[4]) tag = {tag, "R2 R3 R4 "};
        if (v[7]) tag = {tag, "R5 "};
        if (v[8]) begin
          if (v[9] == v[1]) tag = {tag, "R6 "};
          else if (v[9]) tag = {tag, "R7 "};
          else tag = {tag, "R8 "};
        end
        if (v[4] + v[7] + v[8] > 1) tag = {tag, "R10 "};
        if (tag == "") tag = "R6 quiet";
        @(negedge clk);
        check(mask_rdata[1:0] == exp, tag, mask_rdata[1:0], exp);
        check(mask_rdata[W-1:2] == '0 && host_irq == mask_rdata[1], "R1 readback",
              {host_irq, mask_rdata}, {exp[1], {(W-2){1'b0}}, exp});
      end
    end

    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule